// File: doc/BRIEF.md
# Variable Phase Offset Controller

This block holds a signed fine phase offset, counted in steps of 1/256 of a reference clock period, and moves it one step at a time on request. Requests come in on a separate adjust clock. An enable input marks a request, and a direction input chooses whether the offset goes up or down. A single done pulse, also on the adjust clock, reports that the step has taken effect and that the next request may follow.

Each accepted request crosses into the reference clock domain. There the block waits for a settling interval before it writes the new offset to its output register. Completion then crosses back to the adjust clock. Only one request is in flight at a time. The offset saturates at a symmetric limit. An asynchronous reset restores the start offset, which is fixed by a parameter.

Top module: `phase_offset_ctrl`

## Requirements
- R1: While `rst_n` is low, `offset` equals `START_OFFSET` and `adj_done` is 0; both take these values asynchronously, without waiting for a clock edge.
- R2: On a rising `adj_clk` edge with the enable active and no request outstanding, a request is accepted. An active direction level requests +1 step and an inactive level requests −1 step.
- R3: A request that would move `offset` beyond +`LIMIT` or below −`LIMIT` (255 by default) leaves it unchanged, but still produces a done pulse.
- R4: The offset never changes sooner than `SETTLE_CYCLES` `ref_clk` cycles (100 by default) after acceptance. Two successive changes are at least `SETTLE_CYCLES` reference cycles apart.
- R5: Every accepted request produces exactly one `adj_done` pulse, one `adj_clk` cycle wide. It arrives no later than `SETTLE_CYCLES`+4 reference cycles plus four adjust cycles after acceptance, and the new offset is already visible when it arrives.
- R6: From acceptance until the cycle in which `adj_done` is high, the enable input is ignored. Such requests produce no done pulse and no offset change.
- R7: With `EN_INVERT`=1 the enable is active low. With `UP_INVERT`=1 a low direction level requests +1. With the value 0 both are active high.
- R8: The offset changes by exactly one step each time it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; settling counter and offset register |
| adj_clk | input | 1 | Adjust clock; request and done handshake |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| adj_en | input | 1 | Request enable, polarity set by `EN_INVERT` |
| adj_up | input | 1 | Step direction, polarity set by `UP_INVERT` |
| adj_done | output | 1 | One-cycle completion pulse on `adj_clk` |
| offset | output | OFS_W | Signed phase offset in 1/256-period steps (`ref_clk` domain) |

## Verification
On every cycle the checker confirms four things: the offset stays within ±`LIMIT`, it moves only by single steps, those steps are spaced at least the settling interval apart, and the done pulse never lasts more than one adjust cycle. Several behaviours can only be shown by the bench's scenarios. These are the direction and value of each step, the silent saturation at both limits, the dropping of enables while a request is pending, the latency window measured from acceptance to done, the inverted-polarity variant, and a reset that lands while a request is still in flight.

// File: rtl/pofs_pkg.sv
package pofs_pkg;
  typedef enum logic {
    STEP_DOWN = 1'b0,
    STEP_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/pofs_sync.sv
// Multi-stage synchronizer with asynchronous clear; also used as a reset
// synchronizer when d is tied high.
module pofs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d};
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/pofs_adj_side.sv
// Adjust-clock domain: request capture, busy tracking, done pulse.
module pofs_adj_side
  import pofs_pkg::*;
#(
  parameter bit EN_INVERT = 1'b0,
  parameter bit UP_INVERT = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_i,
  input  logic      up_i,
  input  logic      ack_tgl_s,
  output logic      req_tgl_o,
  output step_dir_e dir_o,
  output logic      done_o
);
  logic      en_act, up_act, ack_evt;
  logic      busy_q, busy_d;
  logic      req_q, req_d;
  logic      seen_q;
  logic      done_q, done_d;
  step_dir_e dir_q, dir_d;

  assign en_act  = en_i ^ EN_INVERT;
  assign up_act  = up_i ^ UP_INVERT;
  assign ack_evt = ack_tgl_s ^ seen_q;

  always_comb begin
    busy_d = busy_q;
    req_d  = req_q;
    dir_d  = dir_q;
    done_d = 1'b0;
    if (busy_q) begin
      if (ack_evt) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (en_act) begin
      busy_d = 1'b1;
      req_d  = ~req_q;
      dir_d  = up_act ? STEP_UP : STEP_DOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      dir_q  <= STEP_DOWN;
      done_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      dir_q  <= dir_d;
      done_q <= done_d;
      seen_q <= ack_tgl_s;
    end
  end

  assign req_tgl_o = req_q;
  assign dir_o     = dir_q;
  assign done_o    = done_q;
endmodule

// File: rtl/pofs_ref_side.sv
// Reference-clock domain: settling counter and saturating offset register.
module pofs_ref_side
  import pofs_pkg::*;
#(
  parameter int START_OFFSET  = 0,
  parameter int LIMIT         = 255,
  parameter int SETTLE_CYCLES = 100,
  parameter int OFS_W         = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_tgl_s,
  input  step_dir_e               dir_i,
  output logic                    ack_tgl_o,
  output logic signed [OFS_W-1:0] offset_o
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0]         CNT_LOAD  = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic signed [OFS_W-1:0]  START_OFS = OFS_W'(START_OFFSET);
  localparam logic signed [OFS_W-1:0]  LIM_POS   = OFS_W'(LIMIT);
  localparam logic signed [OFS_W-1:0]  LIM_NEG   = OFS_W'(-LIMIT);
  localparam logic signed [OFS_W-1:0]  ONE       = OFS_W'(1);

  logic                    seen_q, new_req;
  logic                    pend_q, pend_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  step_dir_e               dir_q, dir_d;
  logic                    ack_q, ack_d;
  logic signed [OFS_W-1:0] off_q, off_d, off_step;

  assign new_req = req_tgl_s ^ seen_q;

  always_comb begin
    if (dir_q == STEP_UP) off_step = (off_q >= LIM_POS) ? off_q : off_q + ONE;
    else                  off_step = (off_q <= LIM_NEG) ? off_q : off_q - ONE;
  end

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    ack_d  = ack_q;
    off_d  = off_q;
    if (pend_q) begin
      if (cnt_q == '0) begin
        pend_d = 1'b0;
        ack_d  = ~ack_q;
        off_d  = off_step;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (new_req) begin
      pend_d = 1'b1;
      cnt_d  = CNT_LOAD;
      dir_d  = dir_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      dir_q  <= STEP_DOWN;
      ack_q  <= 1'b0;
      off_q  <= START_OFS;
    end else begin
      seen_q <= req_tgl_s;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      ack_q  <= ack_d;
      off_q  <= off_d;
    end
  end

  assign ack_tgl_o = ack_q;
  assign offset_o  = off_q;
endmodule

// File: rtl/phase_offset_ctrl.sv
module phase_offset_ctrl
  import pofs_pkg::*;
#(
  parameter int START_OFFSET  = 0,
  parameter int LIMIT         = 255,
  parameter int SETTLE_CYCLES = 100,
  parameter bit EN_INVERT     = 1'b0,
  parameter bit UP_INVERT     = 1'b0,
  localparam int OFS_W        = $clog2(LIMIT + 1) + 1
) (
  input  logic                    ref_clk,
  input  logic                    adj_clk,
  input  logic                    rst_n,
  input  logic                    adj_en,
  input  logic                    adj_up,
  output logic                    adj_done,
  output logic signed [OFS_W-1:0] offset
);
  logic      ref_rst_n, adj_rst_n;
  logic      req_tgl, req_tgl_s, ack_tgl, ack_tgl_s;
  step_dir_e dir;

  pofs_sync #(.STAGES(2)) u_ref_rst (
    .clk(ref_clk), .arst_n(rst_n), .d(1'b1), .q(ref_rst_n));
  pofs_sync #(.STAGES(2)) u_adj_rst (
    .clk(adj_clk), .arst_n(rst_n), .d(1'b1), .q(adj_rst_n));

  pofs_adj_side #(.EN_INVERT(EN_INVERT), .UP_INVERT(UP_INVERT)) u_adj (
    .clk(adj_clk), .rst_n(adj_rst_n), .en_i(adj_en), .up_i(adj_up),
    .ack_tgl_s(ack_tgl_s), .req_tgl_o(req_tgl), .dir_o(dir), .done_o(adj_done));

  pofs_sync #(.STAGES(2)) u_req_sync (
    .clk(ref_clk), .arst_n(ref_rst_n), .d(req_tgl), .q(req_tgl_s));
  pofs_sync #(.STAGES(2)) u_ack_sync (
    .clk(adj_clk), .arst_n(adj_rst_n), .d(ack_tgl), .q(ack_tgl_s));

  pofs_ref_side #(
    .START_OFFSET(START_OFFSET), .LIMIT(LIMIT),
    .SETTLE_CYCLES(SETTLE_CYCLES), .OFS_W(OFS_W)
  ) u_ref (
    .clk(ref_clk), .rst_n(ref_rst_n), .req_tgl_s(req_tgl_s), .dir_i(dir),
    .ack_tgl_o(ack_tgl), .offset_o(offset));
endmodule

// File: rtl/pofs_checker.sv
module pofs_checker #(
  parameter int START_OFFSET  = 0,
  parameter int LIMIT         = 255,
  parameter int SETTLE_CYCLES = 100,
  parameter int OFS_W         = 9
) (
  input logic                    ref_clk,
  input logic                    adj_clk,
  input logic                    rst_n,
  input logic                    adj_done,
  input logic signed [OFS_W-1:0] offset
);
  localparam int GAP_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(SETTLE_CYCLES);

  logic signed [OFS_W-1:0] prev_q;
  logic [GAP_W-1:0]        gap_q;
  logic                    chg;

  assign chg = (offset != prev_q);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= OFS_W'(START_OFFSET);
      gap_q  <= GAP_MAX;
    end else begin
      prev_q <= offset;
      if (chg)                gap_q <= '0;
      else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end
  end

  a_r3_within_limit: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (offset <= OFS_W'(LIMIT)) && (offset >= OFS_W'(-LIMIT)));

  a_r8_single_step: assert property (@(posedge ref_clk) disable iff (!rst_n)
    chg |-> ((offset - prev_q) == OFS_W'(1) || (prev_q - offset) == OFS_W'(1)));

  a_r4_change_spacing: assert property (@(posedge ref_clk) disable iff (!rst_n)
    chg |-> (gap_q == GAP_MAX));

  a_r5_done_one_cycle: assert property (@(posedge adj_clk) disable iff (!rst_n)
    adj_done |=> !adj_done);
endmodule

bind phase_offset_ctrl pofs_checker #(
  .START_OFFSET(START_OFFSET), .LIMIT(LIMIT),
  .SETTLE_CYCLES(SETTLE_CYCLES), .OFS_W(OFS_W)
) i_chk (
  .ref_clk(ref_clk), .adj_clk(adj_clk), .rst_n(rst_n),
  .adj_done(adj_done), .offset(offset));

// File: tb/test_phase_offset_ctrl.sv
module test_phase_offset_ctrl;
  localparam int LIM    = 255;
  localparam int SET    = 100;
  localparam int START  = 0;
  localparam int ADJ_T  = 20;
  localparam int REF_T  = 16;

  logic adj_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, up = 1'b0;
  logic en2 = 1'b1, up2 = 1'b1;
  logic done, done2;
  logic signed [8:0] ofs, ofs2;

  always #(ADJ_T/2) adj_clk = ~adj_clk;
  always #(REF_T/2) ref_clk = ~ref_clk;

  phase_offset_ctrl #(.START_OFFSET(START), .LIMIT(LIM), .SETTLE_CYCLES(SET)) i_phase_offset_ctrl (
    .ref_clk(ref_clk), .adj_clk(adj_clk), .rst_n(rst_n),
    .adj_en(en), .adj_up(up), .adj_done(done), .offset(ofs));

  phase_offset_ctrl #(.START_OFFSET(-3), .LIMIT(LIM), .SETTLE_CYCLES(4),
                      .EN_INVERT(1'b1), .UP_INVERT(1'b1)) i_phase_offset_ctrl_inv (
    .ref_clk(ref_clk), .adj_clk(adj_clk), .rst_n(rst_n),
    .adj_en(en2), .adj_up(up2), .adj_done(done2), .offset(ofs2));

  int     n_vec = 0, n_bad = 0;
  int     exp_q[$];
  int     model = START;
  int     last_seen = START;
  bit     outstanding = 1'b0;
  bit     prev_done = 1'b0;
  longint t_req = 0;
  bit     finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Driver: one request, expected offset pushed to the scoreboard.
  task automatic request(input bit dir);
    while (outstanding) @(negedge adj_clk);
    if (dir) model = (model >= LIM) ? model : model + 1;
    else     model = (model <= -LIM) ? model : model - 1;
    exp_q.push_back(model);
    outstanding = 1'b1;
    en = 1'b1;
    up = dir;
    t_req = $time + ADJ_T/2;
    @(negedge adj_clk);
    en = 1'b0;
  endtask

  task automatic drain();
    while (outstanding) @(negedge adj_clk);
  endtask

  // Monitor: compares each done against the scoreboard.
  always @(negedge adj_clk) begin
    if (rst_n) begin
      chk(!(prev_done && done), "R5 done width", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          int     e;
          longint lat;
          e   = exp_q.pop_front();
          lat = $time - ADJ_T/2 - t_req;
          chk(int'(ofs) == e, "R2 R3 offset at done", int'(ofs), e);
          chk(int'(ofs) - last_seen <= 1 && last_seen - int'(ofs) <= 1,
              "R8 step size", int'(ofs), last_seen);
          chk(lat >= SET*REF_T, "R4 settle lower bound", lat, SET*REF_T);
          chk(lat <= (SET+4)*REF_T + 4*ADJ_T, "R5 latency bound", lat, (SET+4)*REF_T + 4*ADJ_T);
          last_seen = int'(ofs);
          outstanding = 1'b0;
        end
      end
    end
    prev_done = done;
  end

  initial begin
    repeat (190000) @(posedge adj_clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (5) @(negedge adj_clk);
    chk(int'(ofs) == START && !done, "R1 reset state", int'(ofs), START);
    chk(int'(ofs2) == -3 && !done2, "R1 start offset param", int'(ofs2), -3);
    rst_n = 1'b1;
    repeat (5) @(negedge adj_clk);

    // R2: a few steps each way
    repeat (3) request(1'b1);
    repeat (5) request(1'b0);
    drain();
    chk(int'(ofs) == -2, "R2 mixed steps", int'(ofs), -2);

    // R6: enables during an outstanding request are dropped
    request(1'b1);
    @(negedge adj_clk);
    en = 1'b1; up = 1'b0;
    repeat (3) @(negedge adj_clk);
    en = 1'b0;
    drain();
    repeat (200) @(negedge adj_clk);
    chk(exp_q.size() == 0 && int'(ofs) == model, "R6 ignored while busy", int'(ofs), model);

    // R3: saturate upward, then downward
    while (model < LIM) request(1'b1);
    repeat (2) request(1'b1);
    drain();
    chk(int'(ofs) == LIM, "R3 upper limit", int'(ofs), LIM);
    while (model > -LIM) request(1'b0);
    repeat (2) request(1'b0);
    drain();
    chk(int'(ofs) == -LIM, "R3 lower limit", int'(ofs), -LIM);

    // R7: inverted polarity instance
    repeat (50) @(negedge adj_clk);
    chk(!done2 && int'(ofs2) == -3, "R7 inactive high enable", int'(ofs2), -3);
    en2 = 1'b0; up2 = 1'b0;
    @(negedge adj_clk);
    en2 = 1'b1;
    begin
      int k = 0;
      while (!done2 && k < 100) begin @(negedge adj_clk); k++; end
    end
    chk(done2 && int'(ofs2) == -2, "R7 low direction steps up", int'(ofs2), -2);
    @(negedge adj_clk);
    en2 = 1'b0; up2 = 1'b1;
    @(negedge adj_clk);
    en2 = 1'b1;
    begin
      int k = 0;
      while (!done2 && k < 100) begin @(negedge adj_clk); k++; end
    end
    chk(done2 && int'(ofs2) == -3, "R7 high direction steps down", int'(ofs2), -3);

    // R1: asynchronous reset with a request in flight
    request(1'b1);
    repeat (20) @(negedge adj_clk);
    #3 rst_n = 1'b0;
    #1;
    chk(int'(ofs) == START && !done, "R1 async reset", int'(ofs), START);
    exp_q.delete();
    outstanding = 1'b0;
    model = START;
    last_seen = START;
    repeat (3) @(negedge adj_clk);
    rst_n = 1'b1;
    repeat (300) @(negedge adj_clk);
    chk(int'(ofs) == START, "R1 no residue after reset", int'(ofs), START);
    request(1'b0);
    drain();
    chk(int'(ofs) == START - 1, "R2 step after reset", int'(ofs), START - 1);

    repeat (10) @(negedge adj_clk);
    finish_run();
  end
endmodule